// File: doc/BRIEF.md
# Quad-Channel Serial DAC Command Receiver

This block is the device end of a three-wire serial link that programs a four-channel 8-bit voltage DAC. It samples the host's serial clock, serial data, frame-enable strobe and output-hold strobe with a fast system clock. It shifts in 11-bit command frames and stores each committed frame in one of four channel registers. It drives no analog output. For each channel it reports the held 8-bit code, the range-doubling bit, and a 10-bit scaled value in units of REF/256. It is meant as a synthesizable device model, placed beside a host-side DAC driver in a testbench so that the driver's output can be checked against a known reading of the protocol.

A frame is sent most significant bit first. It starts with two channel-select bits, then the range bit, then the eight code bits. Bits are taken on falling serial-clock edges while the frame-enable strobe is high. A low pulse on the frame-enable strobe commits the frame. Each channel has a staging register and an output register. The hold strobe decides whether a committed frame reaches the output at once or waits for a common update.

Top module: `qdac_rx`

## Requirements
- R1: Each serial input passes through two flip-flops. A bit is captured on a falling edge of the synchronized serial clock only while the synchronized frame-enable level is high. Serial-clock edges seen while frame-enable is low shift nothing.
- R2: Frame bit order on the wire is channel-select bit 1, channel-select bit 0, range bit, then code bits 7 down to 0. The two select bits pick channel 0 to 3.
- R3: If more than 11 bits arrive before frame-enable falls, only the last 11 received form the frame.
- R4: If fewer than 11 bits arrive before frame-enable falls, no channel changes and `frame_err_o` is high for exactly one cycle. This happens on the third rising clock edge that samples frame-enable low.
- R5: A falling frame-enable clears the bit count and the shift register, so the next frame starts from empty.
- R6: While the synchronized hold level is low, a committed frame reaches the channel's outputs on the fourth rising clock edge that samples frame-enable low.
- R7: While the hold level is high, committed frames change only the staging registers and the outputs keep their values. When hold goes low, every channel's outputs take their staged values on the same cycle.
- R8: `ch_scaled_o` for a channel equals the code when the range bit is 0, and twice the code when it is 1. The value is 10 bits wide.
- R9: A synchronous active-low reset clears all codes, range bits, scaled values, update pulses and the error flag.
- R10: `ch_upd_o[i]` is high for one cycle exactly when channel i's output code or range bit changes. Rewriting the same value gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from host; data taken on its falling edge |
| ser_dat_i | input | 1 | Serial data from host |
| frame_en_i | input | 1 | High while shifting; a low pulse commits the frame |
| hold_i | input | 1 | High holds outputs; low passes staged values through |
| ch_code_o | output | 32 | Output codes, channel i in bits [8i+7:8i] |
| ch_rng_o | output | 4 | Range-doubling bit per channel |
| ch_scaled_o | output | 40 | Scaled value per channel, channel i in bits [10i+9:10i] |
| ch_upd_o | output | 4 | One-cycle pulse when a channel's output changes |
| frame_err_o | output | 1 | One-cycle pulse on a frame shorter than 11 bits |

## Verification
Several frame patterns are sent:
- Exact 11-bit frames to each channel, with both range settings. These separate address decoding from range scaling.
- A 13-bit frame. It shows whether the shifter keeps the newest bits or the oldest.
- A 7-bit frame, then a good one. This pair tells a dropped frame apart from a shifter that was not cleared.
- Serial-clock pulses while frame-enable is low. These expose capture that ignores the strobe.
- Frames sent with hold high, then released. These show whether outputs update together or frame by frame.
- The same value rewritten to a channel. This tests that the update pulse tracks real changes only.

A per-cycle reference model pins down the exact latency of every output.

// File: rtl/qdac_pkg.sv
`timescale 1ns / 1ps
package qdac_pkg;
    parameter int unsigned DEF_NCH = 4;
    parameter int unsigned DEF_DW  = 8;

    // select bits + range bit + code bits
    function automatic int unsigned frame_len(int unsigned aw, int unsigned dw);
        return aw + 1 + dw;
    endfunction
endpackage

// File: rtl/qdac_sync.sv
`timescale 1ns / 1ps
module qdac_sync #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o
);
    typedef struct packed {
        logic [N-1:0] st1;
        logic [N-1:0] st2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.st1 = raw_i;
        sync_d.st2 = sync_q.st1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign lvl_o = sync_q.st2;
endmodule

// File: rtl/qdac_edge.sv
`timescale 1ns / 1ps
module qdac_edge #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb prev_d = lvl_i;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/qdac_shift.sv
`timescale 1ns / 1ps
module qdac_shift
    import qdac_pkg::*;
#(
    parameter int unsigned AW = 2,
    parameter int unsigned DW = DEF_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_fall_i,
    input  logic          dat_i,
    input  logic          en_lvl_i,
    input  logic          en_fall_i,
    output logic          commit_o,
    output logic [AW-1:0] addr_o,
    output logic          rng_o,
    output logic [DW-1:0] code_o,
    output logic          err_o
);
    localparam int unsigned FL = frame_len(AW, DW);
    localparam int unsigned CW = $clog2(FL + 1);
    localparam logic [CW-1:0] FULL = CW'(FL);

    typedef struct packed {
        logic [FL-1:0] sh;
        logic [CW-1:0] cnt;
        logic          commit;
        logic          err;
        logic [AW-1:0] addr;
        logic          rng;
        logic [DW-1:0] code;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d        = shf_q;
        shf_d.commit = 1'b0;
        shf_d.err    = 1'b0;
        if (en_fall_i) begin
            if (shf_q.cnt == FULL) begin
                shf_d.commit = 1'b1;
                shf_d.addr   = shf_q.sh[FL-1 -: AW];
                shf_d.rng    = shf_q.sh[DW];
                shf_d.code   = shf_q.sh[DW-1:0];
            end else begin
                shf_d.err = 1'b1;
            end
            shf_d.sh  = '0;
            shf_d.cnt = '0;
        end else if (en_lvl_i && sclk_fall_i) begin
            shf_d.sh = {shf_q.sh[FL-2:0], dat_i};
            if (shf_q.cnt != FULL) shf_d.cnt = shf_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign commit_o = shf_q.commit;
    assign addr_o   = shf_q.addr;
    assign rng_o    = shf_q.rng;
    assign code_o   = shf_q.code;
    assign err_o    = shf_q.err;
endmodule

// File: rtl/qdac_chan.sv
`timescale 1ns / 1ps
module qdac_chan #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic          rng_i,
    input  logic [DW-1:0] code_i,
    input  logic          pass_i,
    output logic [DW-1:0] code_o,
    output logic          rng_o,
    output logic [DW+1:0] scaled_o,
    output logic          upd_o
);
    typedef struct packed {
        logic          stg_rng;
        logic [DW-1:0] stg_code;
        logic          out_rng;
        logic [DW-1:0] out_code;
        logic          upd;
    } chan_t;

    chan_t ch_d, ch_q;

    always_comb begin
        ch_d     = ch_q;
        ch_d.upd = 1'b0;
        if (wr_i) begin
            ch_d.stg_rng  = rng_i;
            ch_d.stg_code = code_i;
        end
        if (pass_i) begin
            ch_d.out_rng  = ch_d.stg_rng;
            ch_d.out_code = ch_d.stg_code;
        end
        ch_d.upd = {ch_d.out_rng, ch_d.out_code} != {ch_q.out_rng, ch_q.out_code};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign code_o   = ch_q.out_code;
    assign rng_o    = ch_q.out_rng;
    assign upd_o    = ch_q.upd;
    assign scaled_o = ch_q.out_rng ? {1'b0, ch_q.out_code, 1'b0}
                                   : {2'b00, ch_q.out_code};
endmodule

// File: rtl/qdac_rx.sv
`timescale 1ns / 1ps
module qdac_rx
    import qdac_pkg::*;
#(
    parameter int unsigned NCH = DEF_NCH,
    parameter int unsigned DW  = DEF_DW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ser_clk_i,
    input  logic                    ser_dat_i,
    input  logic                    frame_en_i,
    input  logic                    hold_i,
    output logic [NCH*DW-1:0]       ch_code_o,
    output logic [NCH-1:0]          ch_rng_o,
    output logic [NCH*(DW+2)-1:0]   ch_scaled_o,
    output logic [NCH-1:0]          ch_upd_o,
    output logic                    frame_err_o
);
    localparam int unsigned AW = $clog2(NCH);
    localparam int unsigned SW = DW + 2;

    // line order inside the synchronizer vector
    localparam int unsigned L_SCLK = 0;
    localparam int unsigned L_DAT  = 1;
    localparam int unsigned L_EN   = 2;
    localparam int unsigned L_HOLD = 3;

    logic [3:0]    lvl;
    logic [1:0]    fall;
    logic          commit;
    logic [AW-1:0] addr;
    logic          rng;
    logic [DW-1:0] code;

    qdac_sync #(.N(4)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({hold_i, frame_en_i, ser_dat_i, ser_clk_i}),
        .lvl_o (lvl)
    );

    qdac_edge #(.N(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({lvl[L_EN], lvl[L_SCLK]}),
        .fall_o (fall)
    );

    qdac_shift #(.AW(AW), .DW(DW)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_fall_i (fall[0]),
        .dat_i       (lvl[L_DAT]),
        .en_lvl_i    (lvl[L_EN]),
        .en_fall_i   (fall[1]),
        .commit_o    (commit),
        .addr_o      (addr),
        .rng_o       (rng),
        .code_o      (code),
        .err_o       (frame_err_o)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        qdac_chan #(.DW(DW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_i     (commit && (addr == AW'(i))),
            .rng_i    (rng),
            .code_i   (code),
            .pass_i   (!lvl[L_HOLD]),
            .code_o   (ch_code_o[i*DW +: DW]),
            .rng_o    (ch_rng_o[i]),
            .scaled_o (ch_scaled_o[i*SW +: SW]),
            .upd_o    (ch_upd_o[i])
        );
    end
endmodule

// File: rtl/qdac_rx_chk.sv
`timescale 1ns / 1ps
module qdac_rx_chk #(
    parameter int unsigned NCH = 4,
    parameter int unsigned DW  = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NCH*DW-1:0]     ch_code_o,
    input logic [NCH-1:0]        ch_rng_o,
    input logic [NCH*(DW+2)-1:0] ch_scaled_o,
    input logic [NCH-1:0]        ch_upd_o,
    input logic                  frame_err_o
);
    localparam int unsigned SW = DW + 2;

    assert_err_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> !frame_err_o);

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (ch_code_o == '0 && ch_rng_o == '0 && ch_upd_o == '0 && !frame_err_o));

    for (genvar i = 0; i < NCH; i++) begin : g_a
        assert_upd_on_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ch_upd_o[i] |-> !$stable({ch_rng_o[i], ch_code_o[i*DW +: DW]}));

        assert_quiet_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_upd_o[i] |-> $stable({ch_rng_o[i], ch_code_o[i*DW +: DW]}));

        assert_scaled_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_scaled_o[i*SW +: SW] >> ch_rng_o[i]) == SW'(ch_code_o[i*DW +: DW]));

        assert_scaled_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ch_rng_o[i] |-> !ch_scaled_o[i*SW]);
    end
endmodule

bind qdac_rx qdac_rx_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ch_code_o   (ch_code_o),
    .ch_rng_o    (ch_rng_o),
    .ch_scaled_o (ch_scaled_o),
    .ch_upd_o    (ch_upd_o),
    .frame_err_o (frame_err_o)
);

// File: tb/sim_qdac_rx.sv
`timescale 1ns / 1ps
module sim_qdac_rx;
    localparam int NCH = 4;
    localparam int DW  = 8;
    localparam int SW  = DW + 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, sdat = 1'b0, fen = 1'b1, hold = 1'b0;
    logic [NCH*DW-1:0] code_w;
    logic [NCH-1:0]    rng_w, upd_w;
    logic [NCH*SW-1:0] scaled_w;
    logic              err_w;

    qdac_rx #(.NCH(NCH), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
        .frame_en_i(fen), .hold_i(hold), .ch_code_o(code_w), .ch_rng_o(rng_w),
        .ch_scaled_o(scaled_w), .ch_upd_o(upd_w), .frame_err_o(err_w)
    );

    always #4 clk = ~clk;

    int checks = 0, errors = 0;

    // behavioural reference: raw-sample histories, per-channel staged/shown values
    int hs[3], hd[3], he[3], hh[3];
    int st_code[NCH], st_rng[NCH], sh_code[NCH], sh_rng[NCH], m_upd[NCH];
    int m_err, m_pend, m_pa, m_pr, m_pc, m_cnt, m_bits;
    int err_seen = 0;
    int upd_seen[NCH];

    initial for (int i = 0; i < NCH; i++) upd_seen[i] = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) begin hs[k] = 0; hd[k] = 0; he[k] = 0; hh[k] = 0; end
            for (int i = 0; i < NCH; i++) begin
                st_code[i] = 0; st_rng[i] = 0; sh_code[i] = 0; sh_rng[i] = 0; m_upd[i] = 0;
            end
            m_err = 0; m_pend = 0; m_pa = 0; m_pr = 0; m_pc = 0; m_cnt = 0; m_bits = 0;
        end else begin
            if (m_pend != 0) begin st_code[m_pa] = m_pc; st_rng[m_pa] = m_pr; end
            for (int i = 0; i < NCH; i++) begin
                m_upd[i] = 0;
                if (hh[1] == 0) begin
                    if (sh_code[i] != st_code[i] || sh_rng[i] != st_rng[i]) m_upd[i] = 1;
                    sh_code[i] = st_code[i];
                    sh_rng[i]  = st_rng[i];
                end
            end
            m_pend = 0; m_err = 0;
            if (he[2] == 1 && he[1] == 0) begin
                if (m_cnt >= 11) begin
                    m_pend = 1;
                    m_pa = (m_bits >> 9) & 3;
                    m_pr = (m_bits >> 8) & 1;
                    m_pc = m_bits & 255;
                end else m_err = 1;
                m_cnt = 0; m_bits = 0;
            end else if (he[1] == 1 && hs[2] == 1 && hs[1] == 0) begin
                m_bits = ((m_bits << 1) | hd[1]) & 'h7FF;
                if (m_cnt < 11) m_cnt++;
            end
            hs[2] = hs[1]; hs[1] = hs[0]; hs[0] = int'(sclk);
            hd[2] = hd[1]; hd[1] = hd[0]; hd[0] = int'(sdat);
            he[2] = he[1]; he[1] = he[0]; he[0] = int'(fen);
            hh[2] = hh[1]; hh[1] = hh[0]; hh[0] = int'(hold);
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit bad = 0;
            checks++;
            for (int i = 0; i < NCH; i++) begin
                automatic int ac = int'(code_w[i*DW +: DW]);
                automatic int ar = int'(rng_w[i]);
                automatic int as = int'(scaled_w[i*SW +: SW]);
                automatic int es = sh_rng[i] != 0 ? sh_code[i] * 2 : sh_code[i];
                if (ac != sh_code[i] || ar != sh_rng[i]) begin
                    $display("FAIL R6 ch%0d code/rng act %0h/%0d exp %0h/%0d t=%0t", i, ac, ar, sh_code[i], sh_rng[i], $time);
                    bad = 1;
                end
                if (as != es) begin
                    $display("FAIL R8 ch%0d scaled act %0h exp %0h", i, as, es);
                    bad = 1;
                end
                if (int'(upd_w[i]) != m_upd[i]) begin
                    $display("FAIL R10 ch%0d upd act %0d exp %0d t=%0t", i, upd_w[i], m_upd[i], $time);
                    bad = 1;
                end
                if (upd_w[i]) upd_seen[i]++;
            end
            if (int'(err_w) != m_err) begin
                $display("FAIL R4 err act %0d exp %0d t=%0t", err_w, m_err, $time);
                bad = 1;
            end
            if (err_w) err_seen++;
            if (bad) errors++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act %0h exp %0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int val, input int nb);
        for (int b = nb - 1; b >= 0; b--) begin
            sdat = ((val >> b) & 1) != 0;
            sclk = 1'b1; wt(4);
            sclk = 1'b0; wt(4);
        end
        fen = 1'b0; wt(4);
        fen = 1'b1; wt(6);
    endtask

    task automatic frame(input int a, input int r, input int c);
        send((a << 9) | (r << 8) | c, 11);
    endtask

    function automatic int code_of(input int ch);
        return int'(code_w[ch*DW +: DW]);
    endfunction

    function automatic int scaled_of(input int ch);
        return int'(scaled_w[ch*SW +: SW]);
    endfunction

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        automatic int e0, u0c, u1c, u2c;
        wt(5); rst_n = 1'b1; wt(3);
        // R9 reset state
        chk("R9 codes after reset", int'(code_w), 0);
        chk("R9 scaled after reset", int'(scaled_w != 0), 0);
        chk("R9 err after reset", int'(err_w), 0);

        // R2 address and order, R6 pass-through, R8 unscaled
        frame(2, 0, 'hA5);
        chk("R2 ch2 code", code_of(2), 'hA5);
        chk("R2 ch0 untouched", code_of(0), 0);
        chk("R8 ch2 scaled rng0", scaled_of(2), 'hA5);
        frame(1, 1, 'hFF);
        chk("R8 ch1 scaled rng1", scaled_of(1), 'h1FE);
        chk("R2 ch1 rng", int'(rng_w[1]), 1);

        // R3 long frame keeps newest 11 bits
        send((3 << 11) | (3 << 9) | (1 << 8) | 'h80, 13);
        chk("R3 ch3 code", code_of(3), 'h80);
        chk("R3 ch3 scaled", scaled_of(3), 'h100);

        // R4 short frame dropped with error pulse
        e0 = err_seen;
        send('h55, 7);
        chk("R4 one err pulse", err_seen - e0, 1);
        chk("R4 ch0 unchanged", code_of(0), 0);

        // R5 shifter cleared: next frame decodes cleanly
        frame(0, 0, 'h3C);
        chk("R5 ch0 after short frame", code_of(0), 'h3C);

        // R1 serial clocks with frame-enable low are not shifted
        e0 = err_seen;
        fen = 1'b0; sdat = 1'b1;
        for (int k = 0; k < 12; k++) begin sclk = 1'b1; wt(4); sclk = 1'b0; wt(4); end
        fen = 1'b1; wt(6);
        chk("R1 no bits while disabled", err_seen - e0, 1);
        chk("R1 ch3 unchanged", code_of(3), 'h80);

        // R7 hold high: stage only, then common release
        hold = 1'b1; wt(6);
        u0c = upd_seen[0]; u1c = upd_seen[1];
        frame(0, 0, 'h11);
        frame(1, 0, 'h22);
        chk("R7 ch0 held", code_of(0), 'h3C);
        chk("R7 ch1 held", code_of(1), 'hFF);
        hold = 1'b0; wt(6);
        chk("R7 ch0 released", code_of(0), 'h11);
        chk("R7 ch1 released", code_of(1), 'h22);
        chk("R10 ch0 one pulse", upd_seen[0] - u0c, 1);
        chk("R10 ch1 one pulse", upd_seen[1] - u1c, 1);

        // R10 same value rewrite: no pulse; range change: pulse
        u2c = upd_seen[2];
        frame(2, 0, 'hA5);
        chk("R10 ch2 same value no pulse", upd_seen[2] - u2c, 0);
        frame(2, 1, 'hA5);
        chk("R10 ch2 range change pulse", upd_seen[2] - u2c, 1);
        chk("R8 ch2 doubled", scaled_of(2), 'h14A);

        // R9 reset in operation
        rst_n = 1'b0; wt(3); rst_n = 1'b1; wt(2);
        chk("R9 codes cleared", int'(code_w), 0);
        chk("R9 ranges cleared", int'(rng_w), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule